// File: doc/BRIEF.md
# Quad Screen-Space Derivative Unit

This block forms per-lane finite differences for a SIMD group of pixel lanes that execute in lockstep. The lanes are split into independent 2x2 quads. Within a quad, every lane reads the operand registers of its neighbours in the same cycle and returns either a horizontal difference (right column minus left column) or a vertical difference (bottom row minus top row). No value is ever taken from a lane of another quad.

Lanes that the primitive does not cover, called helper lanes, still supply their operands, so a covered lane at a primitive edge sees a full quad. The results of helper lanes are then dropped. The output keep-mask repeats the coverage mask, and the data of every dropped lane is forced to zero. Operands are 16-bit signed fixed-point values, and each difference saturates to that range. The result is registered, so it appears one cycle after the operands are accepted. The group width is a parameter; 32 lanes is the default and 64 lanes is also supported.

Top module: `quad_deriv_unit`

## Requirements
- R1: After reset, out_valid is 0, out_keep is all zeros and out_data is all zeros.
- R2: out_valid is 1 exactly in the cycle after a cycle in which in_valid was 1, and 0 otherwise.
- R3: With in_op = 0 (horizontal), lanes 4n and 4n+1 both return v[4n+1] - v[4n], and lanes 4n+2 and 4n+3 both return v[4n+3] - v[4n+2]. Lane bit 0 is the column and lane bit 1 is the row.
- R4: With in_op = 1 (vertical), lanes 4n and 4n+2 both return v[4n+2] - v[4n], and lanes 4n+1 and 4n+3 both return v[4n+3] - v[4n+1].
- R5: A lane's result depends only on the four operands of its own quad (lanes 4n to 4n+3).
- R6: Operands of uncovered lanes are still used in the results of the covered lanes of the same quad. With a single covered lane in a quad, that lane's result is still correct.
- R7: out_keep equals the in_cover value that was accepted with the operands. Lanes whose keep bit is 0 carry zero data.
- R8: A difference above 32767 is output as 32767, and a difference below -32768 is output as -32768.
- R9: While in_valid is 0, out_keep and out_data hold their previous values, whatever the other inputs do.
- R10: With LANES = 64, all 16 quads follow R3 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands, coverage and opcode are valid this cycle |
| in_op | input | 1 | 0 = horizontal difference, 1 = vertical difference |
| in_cover | input | LANES | Coverage bit for each lane |
| in_data | input | LANES*DW | Operand for each lane; lane i is in bits [i*DW +: DW] |
| out_valid | output | 1 | Results are valid |
| out_keep | output | LANES | Lanes whose results are kept |
| out_data | output | LANES*DW | Saturated difference for each lane; zero where out_keep is 0 |

## Verification
Every result is due in the first cycle after the clock edge that accepts its operands, because there is a single register stage. An idle cycle is also due one cycle later, and what it must show is the previous output held unchanged. The driver applies stimulus at the falling edge. For each cycle it pushes one expected item: a computed result, or a repeat of the held result. The monitor samples a quarter period after each rising edge and pops exactly one item. Each comparison is therefore made against the edge that captured that stimulus, and a result that arrives one cycle early or late shows up as a mismatch.

// File: rtl/qdu_pkg.sv
package qdu_pkg;
  typedef enum logic {
    QDU_DX = 1'b0,
    QDU_DY = 1'b1
  } qdu_op_e;

  localparam int QDU_QUAD_LANES = 4;
endpackage

// File: rtl/qdu_sat_sub.sv
module qdu_sat_sub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] minuend,
  input  logic [DW-1:0] subtrahend,
  output logic [DW-1:0] diff
);
  localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0] wide;

  always_comb begin
    wide = {minuend[DW-1], minuend} - {subtrahend[DW-1], subtrahend};
    if (wide[DW] != wide[DW-1]) begin
      diff = wide[DW] ? NEG_LIM : POS_LIM;
    end else begin
      diff = wide[DW-1:0];
    end
    if (!$isunknown({minuend, subtrahend})) begin
      // R8
      sat_sign_chk: assert (($signed(minuend) >= $signed(subtrahend)) ? !diff[DW-1] : diff[DW-1]);
    end
  end
endmodule

// File: rtl/qdu_quad.sv
module qdu_quad
  import qdu_pkg::*;
#(
  parameter int DW = 16
) (
  input  qdu_op_e                           op,
  input  logic [QDU_QUAD_LANES-1:0][DW-1:0] opnd,
  output logic [QDU_QUAD_LANES-1:0][DW-1:0] res
);
  for (genvar p = 0; p < QDU_QUAD_LANES; p++) begin : g_lane
    localparam int COL = p % 2;
    localparam int ROW = p / 2;

    logic [DW-1:0] sel_hi;
    logic [DW-1:0] sel_lo;

    always_comb begin
      if (op == QDU_DX) begin
        sel_hi = opnd[ROW*2 + 1];
        sel_lo = opnd[ROW*2];
      end else begin
        sel_hi = opnd[2 + COL];
        sel_lo = opnd[COL];
      end
    end

    qdu_sat_sub #(.DW(DW)) u_sub (
      .minuend   (sel_hi),
      .subtrahend(sel_lo),
      .diff      (res[p])
    );
  end
endmodule

// File: rtl/qdu_out_stage.sv
module qdu_out_stage #(
  parameter int LANES = 32,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES-1:0]    keep_d,
  input  logic [LANES*DW-1:0] data_d,
  output logic                out_valid,
  output logic [LANES-1:0]    out_keep,
  output logic [LANES*DW-1:0] out_data
);
  logic                valid_q, valid_n;
  logic                load_en;
  logic [LANES-1:0]    keep_q;
  logic [LANES*DW-1:0] data_q;

  always_comb begin
    valid_n = in_valid;
    load_en = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      keep_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_n;
      if (load_en) begin
        keep_q <= keep_d;
        data_q <= data_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_keep  = keep_q;
  assign out_data  = data_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  keep_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_keep == $past(keep_d)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_keep) && $stable(out_data)));

  for (genvar i = 0; i < LANES; i++) begin : g_zero
    // R7
    masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_keep[i] |-> (out_data[i*DW +: DW] == '0));
  end
endmodule

// File: rtl/quad_deriv_unit.sv
module quad_deriv_unit
  import qdu_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_op,
  input  logic [LANES-1:0]    in_cover,
  input  logic [LANES*DW-1:0] in_data,
  output logic                out_valid,
  output logic [LANES-1:0]    out_keep,
  output logic [LANES*DW-1:0] out_data
);
  localparam int QUADS = LANES / QDU_QUAD_LANES;
  localparam int QW    = QDU_QUAD_LANES * DW;

  logic [1:0]          rst_pipe;
  logic                rst_n_s;
  logic [LANES*DW-1:0] res_flat;
  logic [LANES*DW-1:0] res_masked;
  qdu_op_e             op_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  assign op_sel = qdu_op_e'(in_op);

  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    logic [QDU_QUAD_LANES-1:0][DW-1:0] q_in;
    logic [QDU_QUAD_LANES-1:0][DW-1:0] q_res;

    assign q_in = in_data[q*QW +: QW];

    qdu_quad #(.DW(DW)) u_quad (
      .op  (op_sel),
      .opnd(q_in),
      .res (q_res)
    );

    assign res_flat[q*QW +: QW] = q_res;

    // R3
    pair_h_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (in_valid && in_op == 1'b0) |-> (q_res[0] == q_res[1] && q_res[2] == q_res[3]));
    // R4
    pair_v_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (in_valid && in_op == 1'b1) |-> (q_res[0] == q_res[2] && q_res[1] == q_res[3]));
  end

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign res_masked[i*DW +: DW] = in_cover[i] ? res_flat[i*DW +: DW] : '0;
  end

  qdu_out_stage #(.LANES(LANES), .DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_valid (in_valid),
    .keep_d   (in_cover),
    .data_d   (res_masked),
    .out_valid(out_valid),
    .out_keep (out_keep),
    .out_data (out_data)
  );
endmodule

// File: tb/tb_quad_deriv_unit.sv
module tb_quad_deriv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct {
    bit                valid;
    logic [63:0]       keep;
    logic [63:0][15:0] data;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_op;
  logic [63:0]       in_cover;
  logic [63:0][15:0] in_data;
  logic              o32_valid, o64_valid;
  logic [31:0]       o32_keep;
  logic [63:0]       o64_keep;
  logic [511:0]      o32_data;
  logic [1023:0]     o64_data;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  exp_t sb_q[$];
  exp_t last_e;
  exp_t mon_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_deriv_unit #(.LANES(32), .DW(16)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_cover(in_cover[31:0]), .in_data(in_data[31:0]),
    .out_valid(o32_valid), .out_keep(o32_keep), .out_data(o32_data)
  );

  quad_deriv_unit #(.LANES(64), .DW(16)) dut64 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_cover(in_cover), .in_data(in_data),
    .out_valid(o64_valid), .out_keep(o64_keep), .out_data(o64_data)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model(bit op, logic [63:0][15:0] d, int i);
    int base = (i / 4) * 4;
    int p = i % 4;
    int a, b, r;
    if (!op) begin
      a = $signed(d[base + (p & 2) + 1]);
      b = $signed(d[base + (p & 2)]);
    end else begin
      a = $signed(d[base + 2 + (p & 1)]);
      b = $signed(d[base + (p & 1)]);
    end
    r = a - b;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  task automatic drive(input bit v, input bit op, input logic [63:0] cov,
                       input logic [63:0][15:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = v;
    in_op    = op;
    in_cover = cov;
    in_data  = d;
    e = last_e;
    e.valid = v;
    e.tag   = tag;
    if (v) begin
      e.keep = cov;
      for (int i = 0; i < 64; i++) e.data[i] = cov[i] ? model(op, d, i) : 16'h0;
    end
    last_e = e;
    sb_q.push_back(e);
  endtask

  // Monitor: samples a quarter period after each rising edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (sb_q.size() > 0) begin
      mon_e = sb_q.pop_front();
      chk("R2", "valid32", {63'h0, o32_valid}, {63'h0, mon_e.valid});
      chk("R10", "valid64", {63'h0, o64_valid}, {63'h0, mon_e.valid});
      chk("R7", "keep32", {32'h0, o32_keep}, {32'h0, mon_e.keep[31:0]});
      chk("R10", "keep64", o64_keep, mon_e.keep);
      for (int i = 0; i < 32; i++)
        chk(mon_e.tag, $sformatf("lane32_%0d", i), {48'h0, o32_data[i*16 +: 16]}, {48'h0, mon_e.data[i]});
      for (int i = 0; i < 64; i++)
        chk("R10", $sformatf("%s lane64_%0d", mon_e.tag, i), {48'h0, o64_data[i*16 +: 16]}, {48'h0, mon_e.data[i]});
    end
  end

  initial begin : wd
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0][15:0] d;
    logic [63:0][15:0] d2;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_op    = 1'b0;
    in_cover = '0;
    in_data  = '0;
    last_e.valid = 0;
    last_e.keep  = '0;
    last_e.data  = '0;
    last_e.tag   = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "valid", {63'h0, o32_valid}, 64'h0);
    chk("R1", "keep", {32'h0, o32_keep}, 64'h0);
    chk("R1", "data_lo", o32_data[63:0], 64'h0);
    chk("R1", "keep64", o64_keep, 64'h0);

    // R3 horizontal, full coverage
    for (int i = 0; i < 64; i++) d[i] = 16'(i * 37 - 900);
    drive(1, 0, '1, d, "R3");
    // R4 vertical, full coverage, back to back
    drive(1, 1, '1, d, "R4");

    // R6 one covered lane per quad, rotating position
    for (int i = 0; i < 64; i++) d[i] = 16'($urandom);
    drive(1, 0, 64'h1248_1248_1248_1248, d, "R6");
    drive(1, 1, 64'h8421_8421_8421_8421, d, "R6");

    // R5 change only quad 1 operands, quad 0 must not move
    d2 = d;
    for (int i = 4; i < 8; i++) d2[i] = 16'h7000 + 16'(i);
    drive(1, 0, '1, d2, "R5");
    drive(1, 1, '1, d2, "R5");

    // R8 saturation both directions
    for (int i = 0; i < 64; i += 4) begin
      d[i] = 16'h8000; d[i+1] = 16'h7fff; d[i+2] = 16'h7fff; d[i+3] = 16'h8000;
    end
    drive(1, 0, '1, d, "R8");
    drive(1, 1, '1, d, "R8");

    // R9 idle cycles with changing inputs, outputs hold
    for (int i = 0; i < 64; i++) d[i] = 16'($urandom);
    drive(1, 1, 64'h0f0f_3c3c_a5a5_ffff, d, "R7");
    drive(0, 0, 64'h0, '0, "R9");
    drive(0, 1, '1, d2, "R9");

    // Random mixed traffic
    for (int k = 0; k < 24; k++) begin
      for (int i = 0; i < 64; i++) d[i] = 16'($urandom);
      drive(k % 5 != 4, k[0], {$urandom, $urandom}, d, k[0] ? "R4" : "R3");
    end
    drive(0, 0, '0, '0, "R9");
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule